// File: doc/BRIEF.md
# USB Upstream Bus Event Detector

This block watches the decoded state of the upstream USB pair and turns the bus conditions a device must respond to into latched flags. These conditions are long idle periods, bus reset, resume signalling and end of packet. Firmware reads the flags through an 8-bit event word. A read empties the word, except for any bit whose event arrives in the same cycle as the read.

All durations are counted in cycles of a fixed-frequency clock. The cycle counts come from a clock-rate parameter and from parameters for each interval. An 8-bit mask register selects which events may raise one summary flag. The summary flag stays set until the main event word that holds it is read.

Top module: `usb_bus_event_unit`

## Requirements
- R1: Bit 0 of `evt_flags` is set after `line_state` has been J (2'b00) on exactly SUSP_CYC consecutive clock edges. SUSP_CYC equals CLK_KHZ*IDLE_SUSP_US/1000. The bit is not set after SUSP_CYC-1 edges.
- R2: Bit 1 of `evt_flags` is set after WAKE_CYC consecutive J edges, where WAKE_CYC equals CLK_KHZ*IDLE_WAKE_US/1000. The bit is not set after fewer edges.
- R3: Bit 2 of `evt_flags` is set after `line_state` has been SE0 (2'b10) on RST_CYC consecutive edges, where RST_CYC equals CLK_KHZ*SE0_RST_NS/1000000. The bit is not set after fewer edges.
- R4: Any other line value restarts the idle count and the SE0 count. Each event fires at most once per unbroken interval, so clearing a bit during a long interval does not bring it back.
- R5: Bit 3 of `evt_flags` is set on the first edge of a non-J line state while `node_state` is suspend (2'b10). In other node states nothing happens. A non-J state that continues does not set the bit again.
- R6: Bit 4 of `evt_flags` is set on every edge at which `eop_seen` is high.
- R7: `evt_rd` clears all event bits on the next edge. Bits 7..5 always read 0.
- R8: An event that arrives on the same edge as `evt_rd` leaves its bit set.
- R9: `mask_flags` resets to 0. It takes `mask_wdata` on an edge with `mask_we` high.
- R10: `alt_flag` is set on an edge where an event arrives whose mask bit is 1. It is not set when that mask bit is 0. It holds until an edge with `main_rd` high, unless an enabled event arrives on that same edge.
- R11: After reset `evt_flags` is 0 and `alt_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | Decoded line: 00 J/idle, 01 K, 10 SE0, 11 SE1 |
| node_state | input | 2 | Functional state: 00 operational, 01 reset, 10 suspend, 11 resume |
| eop_seen | input | 1 | One-cycle end-of-packet strobe from the receiver |
| evt_rd | input | 1 | Read strobe for the event word (clears it) |
| evt_flags | output | 8 | Latched event word |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Mask write data |
| mask_flags | output | 8 | Current mask register |
| main_rd | input | 1 | Read strobe for the main event word (clears the summary flag) |
| alt_flag | output | 1 | Summary flag of enabled events |

## Verification
Some properties are checked on every cycle. Reserved bits stay 0. An end-of-packet strobe always lands in the word, and a read with no strobe empties that bit. A reset or resume flag appears only after the matching line or node state. The summary flag holds until a read, and it cannot rise while the mask is 0. Mask writes take effect on the next edge. Other behaviour only the bench scenarios can show: exact thresholds (N-1 versus N cycles), counter restart, the once-per-interval rule, and which single mask bit routes which event to the summary flag.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam logic [1:0] LINE_J       = 2'b00;
    localparam logic [1:0] LINE_SE0     = 2'b10;
    localparam logic [1:0] NODE_SUSPEND = 2'b10;

    localparam int EV_IDLE_SHORT = 0;
    localparam int EV_IDLE_LONG  = 1;
    localparam int EV_BUS_RESET  = 2;
    localparam int EV_WAKE       = 3;
    localparam int EV_EOP        = 4;
    localparam int EV_WIDTH      = 8;

    // Cycles of a clock at khz kilohertz in a span of num/den milliseconds.
    function automatic int span_cycles(longint khz, longint num, longint den);
        longint c;
        c = (khz * num) / den;
        return (c < 1) ? 1 : int'(c);
    endfunction

endpackage

// File: rtl/usb_evt_run_timer.sv
module usb_evt_run_timer #(
    parameter int LIMIT_A = 4,
    parameter int LIMIT_B = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hit_a,
    output logic hit_b
);
    localparam int W = $clog2(LIMIT_B + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        hit_a = 1'b0;
        hit_b = 1'b0;
        if (!active) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt != W'(LIMIT_B)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
            hit_a     = (cur_q.cnt == W'(LIMIT_A - 1));
            hit_b     = (cur_q.cnt == W'(LIMIT_B - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/usb_evt_wake_detect.sv
module usb_evt_wake_detect
    import usb_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic [1:0] node_state,
    output logic       wake_hit
);
    typedef struct packed {
        logic armed;
    } wk_t;

    wk_t cur_q, nxt_d;
    logic cond;

    always_comb begin
        cond      = (node_state == NODE_SUSPEND) && (line_state != LINE_J);
        nxt_d     = cur_q;
        nxt_d.armed = cond;
        wake_hit  = cond && !cur_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end
endmodule

// File: rtl/usb_evt_bank.sv
module usb_evt_bank
    import usb_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_WIDTH-1:0] set_vec,
    input  logic                evt_rd,
    input  logic                mask_we,
    input  logic [EV_WIDTH-1:0] mask_wdata,
    input  logic                main_rd,
    output logic [EV_WIDTH-1:0] evt_flags,
    output logic [EV_WIDTH-1:0] mask_flags,
    output logic                alt_flag
);
    typedef struct packed {
        logic [EV_WIDTH-1:0] evt;
        logic [EV_WIDTH-1:0] mask;
        logic                alt;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.evt  = (cur_q.evt & ~{EV_WIDTH{evt_rd}}) | set_vec;
        nxt_d.alt  = (cur_q.alt & ~main_rd) | (|(set_vec & cur_q.mask));
        if (mask_we) nxt_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign evt_flags  = cur_q.evt;
    assign mask_flags = cur_q.mask;
    assign alt_flag   = cur_q.alt;
endmodule

// File: rtl/usb_bus_event_unit.sv
module usb_bus_event_unit
    import usb_evt_pkg::*;
#(
    parameter int CLK_KHZ      = 48000,
    parameter int IDLE_SUSP_US = 3000,
    parameter int IDLE_WAKE_US = 5000,
    parameter int SE0_RST_NS   = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic [1:0] node_state,
    input  logic       eop_seen,
    input  logic       evt_rd,
    output logic [7:0] evt_flags,
    input  logic       mask_we,
    input  logic [7:0] mask_wdata,
    output logic [7:0] mask_flags,
    input  logic       main_rd,
    output logic       alt_flag
);
    localparam int SUSP_CYC = span_cycles(CLK_KHZ, IDLE_SUSP_US, 1000);
    localparam int WAKE_CYC = span_cycles(CLK_KHZ, IDLE_WAKE_US, 1000);
    localparam int RST_CYC  = span_cycles(CLK_KHZ, SE0_RST_NS, 1000000);

    logic idle_short, idle_long, se0_a, se0_b, wake_hit;
    logic [EV_WIDTH-1:0] set_vec;

    // One counter serves both idle thresholds.
    usb_evt_run_timer #(.LIMIT_A(SUSP_CYC), .LIMIT_B(WAKE_CYC)) u_idle (
        .clk(clk), .rst_n(rst_n), .active(line_state == LINE_J),
        .hit_a(idle_short), .hit_b(idle_long)
    );

    // Equal limits: both strobes fire together.
    usb_evt_run_timer #(.LIMIT_A(RST_CYC), .LIMIT_B(RST_CYC)) u_se0 (
        .clk(clk), .rst_n(rst_n), .active(line_state == LINE_SE0),
        .hit_a(se0_a), .hit_b(se0_b)
    );

    usb_evt_wake_detect u_wake (
        .clk(clk), .rst_n(rst_n), .line_state(line_state),
        .node_state(node_state), .wake_hit(wake_hit)
    );

    always_comb begin
        set_vec                = '0;
        set_vec[EV_IDLE_SHORT] = idle_short;
        set_vec[EV_IDLE_LONG]  = idle_long;
        set_vec[EV_BUS_RESET]  = se0_a | se0_b;
        set_vec[EV_WAKE]       = wake_hit;
        set_vec[EV_EOP]        = eop_seen;
    end

    usb_evt_bank u_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .evt_rd(evt_rd),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .main_rd(main_rd),
        .evt_flags(evt_flags), .mask_flags(mask_flags), .alt_flag(alt_flag)
    );
endmodule

// File: rtl/usb_bus_event_chk.sv
module usb_bus_event_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_state,
    input logic [1:0] node_state,
    input logic       eop_seen,
    input logic       evt_rd,
    input logic [7:0] evt_flags,
    input logic       mask_we,
    input logic [7:0] mask_wdata,
    input logic [7:0] mask_flags,
    input logic       main_rd,
    input logic       alt_flag
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flags[7:5] == 3'b000); // R7
    AST_EOP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        eop_seen |=> evt_flags[4]); // R6
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && !eop_seen) |=> !evt_flags[4]); // R7
    AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[2]) |-> $past(line_state == 2'b10)); // R3
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flags[3]) |-> $past(node_state == 2'b10 && line_state != 2'b00)); // R5
    AST_ALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_flag && !main_rd) |=> alt_flag); // R10
    AST_ALT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_flags == 8'h00 && !alt_flag) |=> !alt_flag); // R10
    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_flags == $past(mask_wdata)); // R9
endmodule

bind usb_bus_event_unit usb_bus_event_chk u_chk (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .node_state(node_state),
    .eop_seen(eop_seen), .evt_rd(evt_rd), .evt_flags(evt_flags),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_flags(mask_flags),
    .main_rd(main_rd), .alt_flag(alt_flag)
);

// File: tb/usb_bus_event_unit_test.sv
module usb_bus_event_unit_test;
    localparam int SUSP = 12;
    localparam int WAKE = 20;
    localparam int RSTC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic [1:0] node_state = 2'b00;
    logic eop_seen = 1'b0, evt_rd = 1'b0, mask_we = 1'b0, main_rd = 1'b0;
    logic [7:0] mask_wdata = 8'h00;
    logic [7:0] evt_flags, mask_flags;
    logic alt_flag;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_bus_event_unit #(.CLK_KHZ(1000), .IDLE_SUSP_US(SUSP), .IDLE_WAKE_US(WAKE),
                         .SE0_RST_NS(RSTC * 1000)) uut (
        .clk(clk), .rst_n(rst_n), .line_state(line_state), .node_state(node_state),
        .eop_seen(eop_seen), .evt_rd(evt_rd), .evt_flags(evt_flags),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_flags(mask_flags),
        .main_rd(main_rd), .alt_flag(alt_flag)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        evt_rd = 1'b1; main_rd = 1'b1; tick(1);
        evt_rd = 1'b0; main_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - bad, total);
            $finish;
        end
    end

    initial begin
        tick(2);
        chk("R11 evt", evt_flags, 8'h00);
        chk("R11 alt", {7'd0, alt_flag}, 8'h00);
        chk("R9 reset mask", mask_flags, 8'h00);
        rst_n = 1'b1;
        tick(1);

        // R1 R2: idle length sweep
        for (int n = 1; n <= WAKE + 3; n++) begin
            line_state = 2'b01; clear_all();
            line_state = 2'b00; tick(n);
            line_state = 2'b01; tick(1);
            chk($sformatf("R1/R2 idle n=%0d", n), evt_flags,
                {6'd0, n >= WAKE, n >= SUSP});
        end

        // R3: SE0 length sweep
        for (int n = 1; n <= RSTC + 3; n++) begin
            line_state = 2'b01; clear_all();
            line_state = 2'b10; tick(n);
            line_state = 2'b01; tick(1);
            chk($sformatf("R3 se0 n=%0d", n), evt_flags, (n >= RSTC) ? 8'h04 : 8'h00);
        end

        // R4: once per interval, restart after break
        line_state = 2'b01; clear_all();
        line_state = 2'b00; tick(WAKE + 2);
        evt_rd = 1'b1; tick(1); evt_rd = 1'b0;
        tick(10);
        chk("R4 no refire idle", evt_flags, 8'h00);
        line_state = 2'b01; tick(1);
        line_state = 2'b00; tick(SUSP);
        chk("R4 restart idle", evt_flags, 8'h01);
        line_state = 2'b10; clear_all(); tick(RSTC + 4);
        evt_rd = 1'b1; tick(1); evt_rd = 1'b0; tick(4);
        chk("R4 no refire se0", evt_flags, 8'h00);

        // R5: resume across node and line states
        for (int ns = 0; ns < 4; ns++) begin
            for (int ls = 1; ls < 4; ls++) begin
                line_state = 2'b00; node_state = 2'(ns); clear_all();
                line_state = 2'(ls); tick(1);
                chk($sformatf("R5 node=%0d line=%0d", ns, ls), evt_flags,
                    (ns == 2) ? 8'h08 : 8'h00);
                evt_rd = 1'b1; tick(1); evt_rd = 1'b0;
                chk($sformatf("R5 held node=%0d line=%0d", ns, ls), evt_flags, 8'h00);
            end
        end
        node_state = 2'b00; line_state = 2'b01;

        // R6 R7 R8: eop, clear, collision with read
        clear_all();
        eop_seen = 1'b1; tick(1); eop_seen = 1'b0;
        chk("R6 eop", evt_flags, 8'h10);
        eop_seen = 1'b1; evt_rd = 1'b1; tick(1); eop_seen = 1'b0; evt_rd = 1'b0;
        chk("R8 read collision", evt_flags, 8'h10);
        evt_rd = 1'b1; tick(1); evt_rd = 1'b0;
        chk("R7 read clears", evt_flags, 8'h00);

        // R9 R10: mask routing sweep with eop event
        for (int b = 0; b < 8; b++) begin
            mask_we = 1'b1; mask_wdata = 8'(1 << b); tick(1); mask_we = 1'b0;
            chk($sformatf("R9 mask b=%0d", b), mask_flags, 8'(1 << b));
            clear_all();
            eop_seen = 1'b1; tick(1); eop_seen = 1'b0;
            chk($sformatf("R10 alt b=%0d", b), {7'd0, alt_flag}, (b == 4) ? 8'h01 : 8'h00);
        end
        mask_we = 1'b1; mask_wdata = 8'h01; tick(1); mask_we = 1'b0;
        clear_all();
        line_state = 2'b00; tick(SUSP); line_state = 2'b01;
        chk("R10 alt idle", {7'd0, alt_flag}, 8'h01);
        evt_rd = 1'b1; tick(5); evt_rd = 1'b0;
        chk("R10 alt holds", {7'd0, alt_flag}, 8'h01);
        main_rd = 1'b1; tick(1); main_rd = 1'b0;
        chk("R10 alt cleared", {7'd0, alt_flag}, 8'h00);
        mask_we = 1'b1; mask_wdata = 8'h10; tick(1); mask_we = 1'b0;
        eop_seen = 1'b1; main_rd = 1'b1; tick(1); eop_seen = 1'b0; main_rd = 1'b0;
        chk("R10 alt read collision", {7'd0, alt_flag}, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end
endmodule